// File: doc/BRIEF.md
# Long-Descriptor Multi-Level Table Walker

This block translates a 48-bit virtual address by walking a tree of 64-bit long-format descriptors laid out with a 4 KB granule. A walk is started with the virtual address, the level to begin at (0 to 3) and the base of the first table. The walker then fetches one descriptor per level over a simple request/response memory port, with one read outstanding at a time. Each descriptor either ends the walk (block, page or fault) or points to the next table.

Along the way the walker collects the restrictions that table descriptors impose on everything below them: non-secure, read-only, no unprivileged access, no execute and no privileged execute. These are merged into the leaf's own permission bits. When the walk ends, the block pulses `done_o` for one cycle with the output address, the page size as an offset width, the permission and memory-attribute fields, the fault code and the level at which the walk stopped.

Top module: `ldw_walker`

## Requirements
- R1: After reset, and with no walk in progress, `req_ready_o` is 1, while `mem_req_valid_o` and `done_o` are 0.
- R2: The descriptor read at level L uses the address formed from the table base bits 47:12, with VA bits [12+9*(3-L)+8 : 12+9*(3-L)] placed in bits 11:3 and bits 2:0 zero. The first read takes its base from `req_base_i`. Each later read takes its base from bits 47:12 of the previous table descriptor.
- R3: The descriptor kind comes from bits 1:0. Bit 0 clear means invalid. Value 11 at levels 0 to 2 is a table, and the walk descends. Value 01 at levels 1 and 2 is a block. Value 11 at level 3 is a page. Value 01 at level 0 or 3 is illegal. Invalid and illegal descriptors give fault code 1 (translation). `end_level_o` reports the level of the last descriptor read, whether or not the walk faulted.
- R4: A leaf gives `pa_o` = descriptor bits 47:n joined with VA bits n-1:0, where n is 30 at level 1, 21 at level 2 and 12 at level 3. `page_shift_o` equals n.
- R5: A leaf drives the following outputs straight from its own bits: `contig_o` from bit 52, `ng_o` from bit 11, `sh_o` from bits 9:8 and `attr_idx_o` from bits 4:2.
- R6: The hierarchical restrictions combine as follows:
  - `xn_o` is leaf bit 54 ORed with bit 60 of every table on the path.
  - `pxn_o` is leaf bit 53 ORed with every table bit 59.
  - `ns_o` is leaf bit 5 ORed with every table bit 63.
  - `ap_o[1]` (read-only) is leaf bit 7 ORed with every table bit 62.
  - `ap_o[0]` (unprivileged access) is leaf bit 6, cleared if any table has bit 61 set.
- R7: A leaf whose access-flag bit 10 is clear gives fault code 2.
- R8: A leaf whose output address has any bit set at or above bit `pa_bits_i` gives fault code 3. This takes precedence over fault code 2.
- R9: On any fault, `pa_o`, `page_shift_o` and all permission and attribute outputs are 0. Only `fault_o` and `end_level_o` carry information.
- R10: A memory request holds `mem_req_valid_o` and a stable address until `mem_req_ready_i`. A response is taken only while one is awaited, and responses arriving at other times are ignored.
- R11: `req_ready_o` stays low from acceptance of a walk until `done_o`. `done_o` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Start a walk |
| req_ready_o | output | 1 | Walker idle, walk start accepted |
| req_va_i | input | 48 | Virtual address to translate |
| req_level_i | input | 2 | Starting lookup level |
| req_base_i | input | 48 | Base address of the starting table |
| pa_bits_i | input | 6 | Width of the permitted output address range |
| mem_req_valid_o | output | 1 | Descriptor read request |
| mem_req_ready_i | input | 1 | Memory accepts the request |
| mem_req_addr_o | output | 48 | Descriptor address |
| mem_rsp_valid_i | input | 1 | Descriptor data valid |
| mem_rsp_data_i | input | 64 | Descriptor data |
| done_o | output | 1 | Walk finished, results valid this cycle |
| pa_o | output | 48 | Translated output address |
| page_shift_o | output | 6 | Offset width of the mapping |
| xn_o | output | 1 | Execute never, merged |
| pxn_o | output | 1 | Privileged execute never, merged |
| ns_o | output | 1 | Non-secure output, merged |
| ap_o | output | 2 | {read-only, unprivileged access}, merged |
| ng_o | output | 1 | Not-global |
| sh_o | output | 2 | Shareability |
| attr_idx_o | output | 3 | Memory attribute index |
| contig_o | output | 1 | Contiguous hint |
| fault_o | output | 2 | 0 none, 1 translation, 2 access flag, 3 address size |
| end_level_o | output | 2 | Level of the last descriptor read |

## Verification
The checks assume that `pa_bits_i` holds steady from the start of a walk until its `done_o`, lies between 32 and 48, and that the memory returns exactly one response per accepted request. The bench changes `pa_bits_i` only between walks. It sends one response on the cycle after each accepted request. It also puts stray responses on the port only while the walker is idle, so that the response assumption is never broken inside a walk. Table bases and leaf addresses in the stimulus are aligned to their granule, block or page sizes, so the address-formation checks see no overlap between base and index bits.

// File: rtl/ldw_pkg.sv
package ldw_pkg;
  typedef enum logic [1:0] {
    FLT_NONE   = 2'd0,
    FLT_TRANS  = 2'd1,
    FLT_ACCESS = 2'd2,
    FLT_ADDR   = 2'd3
  } fault_e;

  typedef enum logic [1:0] {
    DK_FAULT = 2'd0,
    DK_TABLE = 2'd1,
    DK_LEAF  = 2'd2
  } dkind_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } walk_st_e;

  // restrictions gathered from table descriptors
  typedef struct packed {
    logic ns;
    logic ro;
    logic no_user;
    logic xn;
    logic pxn;
  } hier_t;
endpackage

// File: rtl/ldw_index.sv
module ldw_index #(
  parameter int VA_W   = 48,
  parameter int GRAIN  = 12,
  parameter int LEVELS = 4,
  localparam int STRIDE = GRAIN - 3,
  localparam int LVL_W  = $clog2(LEVELS)
) (
  input  logic [VA_W-1:0]   va_i,
  input  logic [LVL_W-1:0]  lvl_i,
  output logic [STRIDE-1:0] idx_o
);
  logic [STRIDE-1:0] slice [LEVELS];

  for (genvar g = 0; g < LEVELS; g++) begin : g_slice
    localparam int LSB = GRAIN + STRIDE * (LEVELS - 1 - g);
    assign slice[g] = va_i[LSB +: STRIDE];
  end

  assign idx_o = slice[lvl_i];
endmodule

// File: rtl/ldw_classify.sv
module ldw_classify
  import ldw_pkg::*;
#(
  parameter int LEVELS      = 4,
  parameter int MIN_BLK_LVL = 1,
  localparam int LVL_W      = $clog2(LEVELS)
) (
  input  logic [1:0]       typ_i,
  input  logic [LVL_W-1:0] lvl_i,
  output dkind_e           kind_o
);
  logic last_lvl, blk_ok;

  assign last_lvl = (lvl_i == LVL_W'(LEVELS - 1));
  assign blk_ok   = (lvl_i >= LVL_W'(MIN_BLK_LVL)) && !last_lvl;

  always_comb begin
    if (!typ_i[0])     kind_o = DK_FAULT;
    else if (typ_i[1]) kind_o = last_lvl ? DK_LEAF : DK_TABLE;
    else               kind_o = blk_ok ? DK_LEAF : DK_FAULT;
  end
endmodule

// File: rtl/ldw_leaf.sv
module ldw_leaf
  import ldw_pkg::*;
#(
  parameter int PA_W   = 48,
  parameter int VA_W   = 48,
  parameter int GRAIN  = 12,
  parameter int LEVELS = 4,
  localparam int STRIDE = GRAIN - 3,
  localparam int LVL_W  = $clog2(LEVELS),
  localparam int SH_W   = $clog2(PA_W),
  localparam int PAB_W  = $clog2(PA_W + 1)
) (
  input  logic [63:0]      desc_i,
  input  logic [VA_W-1:0]  va_i,
  input  logic [LVL_W-1:0] lvl_i,
  input  hier_t            hier_i,
  input  logic [PAB_W-1:0] pa_bits_i,
  output logic [PA_W-1:0]  pa_o,
  output logic [SH_W-1:0]  shift_o,
  output logic             xn_o,
  output logic             pxn_o,
  output logic             ns_o,
  output logic [1:0]       ap_o,
  output fault_e           fault_o
);
  logic [SH_W-1:0] sh_tab [LEVELS];
  logic [PA_W-1:0] hi_mask;
  logic            too_big;
  logic            unused_bits;

  for (genvar g = 0; g < LEVELS; g++) begin : g_shift
    assign sh_tab[g] = SH_W'(GRAIN + STRIDE * (LEVELS - 1 - g));
  end

  assign shift_o = sh_tab[lvl_i];
  assign hi_mask = {PA_W{1'b1}} << shift_o;
  assign pa_o    = (desc_i[PA_W-1:0] & hi_mask) | (va_i[PA_W-1:0] & ~hi_mask);
  assign too_big = (pa_o >> pa_bits_i) != '0;

  assign xn_o  = desc_i[54] | hier_i.xn;
  assign pxn_o = desc_i[53] | hier_i.pxn;
  assign ns_o  = desc_i[5]  | hier_i.ns;
  assign ap_o  = {desc_i[7] | hier_i.ro, desc_i[6] & ~hier_i.no_user};

  always_comb begin
    if (too_big)         fault_o = FLT_ADDR;
    else if (!desc_i[10]) fault_o = FLT_ACCESS;
    else                 fault_o = FLT_NONE;
  end

  assign unused_bits = ^{desc_i[63:55], desc_i[52:PA_W], desc_i[11], desc_i[9:8], desc_i[4:0],
                         va_i[VA_W-1:PA_W-1]};
endmodule

// File: rtl/ldw_walker.sv
module ldw_walker
  import ldw_pkg::*;
#(
  parameter int VA_W        = 48,
  parameter int PA_W        = 48,
  parameter int GRAIN       = 12,
  parameter int LEVELS      = 4,
  parameter int MIN_BLK_LVL = 1,
  localparam int STRIDE = GRAIN - 3,
  localparam int LVL_W  = $clog2(LEVELS),
  localparam int SH_W   = $clog2(PA_W),
  localparam int PAB_W  = $clog2(PA_W + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [VA_W-1:0]  req_va_i,
  input  logic [LVL_W-1:0] req_level_i,
  input  logic [PA_W-1:0]  req_base_i,
  input  logic [PAB_W-1:0] pa_bits_i,
  output logic             mem_req_valid_o,
  input  logic             mem_req_ready_i,
  output logic [PA_W-1:0]  mem_req_addr_o,
  input  logic             mem_rsp_valid_i,
  input  logic [63:0]      mem_rsp_data_i,
  output logic             done_o,
  output logic [PA_W-1:0]  pa_o,
  output logic [SH_W-1:0]  page_shift_o,
  output logic             xn_o,
  output logic             pxn_o,
  output logic             ns_o,
  output logic [1:0]       ap_o,
  output logic             ng_o,
  output logic [1:0]       sh_o,
  output logic [2:0]       attr_idx_o,
  output logic             contig_o,
  output logic [1:0]       fault_o,
  output logic [LVL_W-1:0] end_level_o
);
  walk_st_e          st_q;
  logic [VA_W-1:0]   va_q;
  logic [LVL_W-1:0]  lvl_q;
  logic [PA_W-1:0]   addr_q;
  logic [PAB_W-1:0]  pab_q;
  hier_t             hier_q;

  logic              idle, accept, take_rsp;
  logic [VA_W-1:0]   idx_va;
  logic [LVL_W-1:0]  idx_lvl;
  logic [STRIDE-1:0] idx;
  logic [PA_W-1:0]   tbase, next_addr;
  dkind_e            kind;

  logic [PA_W-1:0]   lf_pa;
  logic [SH_W-1:0]   lf_shift;
  logic              lf_xn, lf_pxn, lf_ns;
  logic [1:0]        lf_ap;
  fault_e            lf_fault;
  logic              unused_bits;

  assign idle     = (st_q == ST_IDLE);
  assign accept   = idle && req_valid_i;
  assign take_rsp = (st_q == ST_WAIT) && mem_rsp_valid_i;

  // index source: new request when idle, next level while walking
  assign idx_va  = idle ? req_va_i : va_q;
  assign idx_lvl = idle ? req_level_i : lvl_q + LVL_W'(1);
  assign tbase   = idle ? req_base_i : mem_rsp_data_i[PA_W-1:0];
  assign next_addr = {tbase[PA_W-1:GRAIN], idx, 3'b000};

  ldw_index #(.VA_W(VA_W), .GRAIN(GRAIN), .LEVELS(LEVELS)) u_index (
    .va_i  (idx_va),
    .lvl_i (idx_lvl),
    .idx_o (idx)
  );

  ldw_classify #(.LEVELS(LEVELS), .MIN_BLK_LVL(MIN_BLK_LVL)) u_classify (
    .typ_i  (mem_rsp_data_i[1:0]),
    .lvl_i  (lvl_q),
    .kind_o (kind)
  );

  ldw_leaf #(.PA_W(PA_W), .VA_W(VA_W), .GRAIN(GRAIN), .LEVELS(LEVELS)) u_leaf (
    .desc_i    (mem_rsp_data_i),
    .va_i      (va_q),
    .lvl_i     (lvl_q),
    .hier_i    (hier_q),
    .pa_bits_i (pab_q),
    .pa_o      (lf_pa),
    .shift_o   (lf_shift),
    .xn_o      (lf_xn),
    .pxn_o     (lf_pxn),
    .ns_o      (lf_ns),
    .ap_o      (lf_ap),
    .fault_o   (lf_fault)
  );

  // walk control
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      va_q   <= '0;
      lvl_q  <= '0;
      addr_q <= '0;
      pab_q  <= '0;
      hier_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (accept) begin
          st_q   <= ST_REQ;
          va_q   <= req_va_i;
          lvl_q  <= req_level_i;
          addr_q <= next_addr;
          pab_q  <= pa_bits_i;
          hier_q <= '0;
        end
        ST_REQ: if (mem_req_ready_i) st_q <= ST_WAIT;
        ST_WAIT: if (mem_rsp_valid_i) begin
          if (kind == DK_TABLE) begin
            st_q           <= ST_REQ;
            lvl_q          <= lvl_q + LVL_W'(1);
            addr_q         <= next_addr;
            hier_q.ns      <= hier_q.ns      | mem_rsp_data_i[63];
            hier_q.ro      <= hier_q.ro      | mem_rsp_data_i[62];
            hier_q.no_user <= hier_q.no_user | mem_rsp_data_i[61];
            hier_q.xn      <= hier_q.xn      | mem_rsp_data_i[60];
            hier_q.pxn     <= hier_q.pxn     | mem_rsp_data_i[59];
          end else begin
            st_q <= ST_IDLE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // result registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o       <= 1'b0;
      pa_o         <= '0;
      page_shift_o <= '0;
      xn_o         <= 1'b0;
      pxn_o        <= 1'b0;
      ns_o         <= 1'b0;
      ap_o         <= '0;
      ng_o         <= 1'b0;
      sh_o         <= '0;
      attr_idx_o   <= '0;
      contig_o     <= 1'b0;
      fault_o      <= '0;
      end_level_o  <= '0;
    end else begin
      done_o <= take_rsp && (kind != DK_TABLE);
      if (take_rsp && kind != DK_TABLE) begin
        end_level_o <= lvl_q;
        if (kind == DK_LEAF && lf_fault == FLT_NONE) begin
          pa_o         <= lf_pa;
          page_shift_o <= lf_shift;
          xn_o         <= lf_xn;
          pxn_o        <= lf_pxn;
          ns_o         <= lf_ns;
          ap_o         <= lf_ap;
          ng_o         <= mem_rsp_data_i[11];
          sh_o         <= mem_rsp_data_i[9:8];
          attr_idx_o   <= mem_rsp_data_i[4:2];
          contig_o     <= mem_rsp_data_i[52];
          fault_o      <= FLT_NONE;
        end else begin
          pa_o         <= '0;
          page_shift_o <= '0;
          xn_o         <= 1'b0;
          pxn_o        <= 1'b0;
          ns_o         <= 1'b0;
          ap_o         <= '0;
          ng_o         <= 1'b0;
          sh_o         <= '0;
          attr_idx_o   <= '0;
          contig_o     <= 1'b0;
          fault_o      <= (kind == DK_FAULT) ? FLT_TRANS : lf_fault;
        end
      end
    end
  end

  assign req_ready_o     = idle;
  assign mem_req_valid_o = (st_q == ST_REQ);
  assign mem_req_addr_o  = addr_q;
  assign unused_bits     = ^{mem_rsp_data_i[58:55], mem_rsp_data_i[51:PA_W], tbase[GRAIN-1:0]};
endmodule

// File: rtl/ldw_checker.sv
module ldw_checker #(
  parameter int PA_W   = 48,
  parameter int GRAIN  = 12,
  parameter int LEVELS = 4,
  localparam int STRIDE = GRAIN - 3,
  localparam int LVL_W  = $clog2(LEVELS),
  localparam int SH_W   = $clog2(PA_W),
  localparam int PAB_W  = $clog2(PA_W + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_ready_o,
  input logic             mem_req_valid_o,
  input logic             mem_req_ready_i,
  input logic [PA_W-1:0]  mem_req_addr_o,
  input logic             done_o,
  input logic [1:0]       fault_o,
  input logic [PA_W-1:0]  pa_o,
  input logic [SH_W-1:0]  page_shift_o,
  input logic [PAB_W-1:0] pa_bits_i,
  input logic [LVL_W-1:0] end_level_o
);
  assert_req_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o && !mem_req_ready_i |=> mem_req_valid_o && $stable(mem_req_addr_o));

  assert_busy_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o |-> !req_ready_o);

  assert_done_pulse_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_addr_align_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o |-> mem_req_addr_o[2:0] == 3'b000);

  assert_fault_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && fault_o != 2'd0 |-> pa_o == '0 && page_shift_o == '0);

  assert_pa_range_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && fault_o == 2'd0 |-> (pa_o >> pa_bits_i) == '0);

  assert_shift_legal_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && fault_o == 2'd0 |->
      page_shift_o >= SH_W'(GRAIN) && ((int'(page_shift_o) - GRAIN) % STRIDE) == 0);

  assert_no_l0_leaf_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && fault_o == 2'd0 |-> end_level_o != '0);
endmodule

bind ldw_walker ldw_checker #(.PA_W(PA_W), .GRAIN(GRAIN), .LEVELS(LEVELS)) u_chk (.*);

// File: tb/sim_ldw_walker.sv
`timescale 1ns/1ps
module sim_ldw_walker;
  logic        clk = 1'b0;
  logic        rst_ni;
  logic        req_valid_i, req_ready_o;
  logic [47:0] req_va_i, req_base_i;
  logic [1:0]  req_level_i;
  logic [5:0]  pa_bits_i;
  logic        mem_req_valid_o, mem_req_ready_i, mem_rsp_valid_i;
  logic [47:0] mem_req_addr_o;
  logic [63:0] mem_rsp_data_i;
  logic        done_o, xn_o, pxn_o, ns_o, ng_o, contig_o;
  logic [47:0] pa_o;
  logic [5:0]  page_shift_o;
  logic [1:0]  ap_o, sh_o, fault_o, end_level_o;
  logic [2:0]  attr_idx_o;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  ldw_walker u0 (.*, .clk_i(clk));

  function automatic logic [63:0] mk_tbl(bit nst, bit [1:0] apt, bit xnt, bit pxnt, logic [47:0] a);
    return {nst, apt, xnt, pxnt, 11'b0, a[47:12], 10'b0, 2'b11};
  endfunction

  function automatic logic [63:0] mk_leaf(bit xn, bit pxn, bit ct, bit ng, bit af, bit [1:0] sh,
                                          bit [1:0] ap, bit ns, bit [2:0] ai, logic [47:0] a,
                                          bit [1:0] ty);
    return {9'b0, xn, pxn, ct, 4'b0, a[47:12], ng, af, sh, ap, ns, ai, ty};
  endfunction

  typedef struct packed {
    logic [47:0] va;
    logic [1:0]  lvl;
    logic [47:0] base;
    logic [5:0]  pab;
    logic [63:0] d0, d1, d2, d3;
    logic [2:0]  nrd;
    logic [1:0]  e_fault;
    logic [1:0]  e_lvl;
    logic [47:0] e_pa;
    logic [5:0]  e_shift;
    logic        e_xn, e_pxn, e_ns;
    logic [1:0]  e_ap;
    logic [6:0]  e_misc;  // {contig, ng, sh, attr}
  } vec_t;

  localparam logic [47:0] VA0 = 48'h0080_8060_4567;  // L0 idx 1, L1 2, L2 3, L3 4, offset 567
  localparam logic [47:0] VA1 = 48'hFFFF_FFFF_FFFF;
  localparam int NV = 13;

  localparam vec_t VECS [NV] = '{
    // full four-level walk to a page (R2 R3 R4 R5)
    '{VA0, 2'd0, 48'h1000, 6'd48, mk_tbl(0,0,0,0,48'h2000), mk_tbl(0,0,0,0,48'h3000),
      mk_tbl(0,0,0,0,48'h4000), mk_leaf(0,0,0,0,1,2'b11,2'b00,0,3'd5,48'h1234_5000,2'b11),
      3'd4, 2'd0, 2'd3, 48'h1234_5567, 6'd12, 0,0,0, 2'b00, {1'b0,1'b0,2'b11,3'd5}},
    // level 1 block (R4 R5)
    '{VA0, 2'd1, 48'h1000, 6'd48, mk_leaf(1,0,1,1,1,2'b10,2'b01,1,3'd2,48'h4000_0000,2'b01),
      64'h0, 64'h0, 64'h0, 3'd1, 2'd0, 2'd1, 48'h4060_4567, 6'd30, 1,0,1, 2'b01,
      {1'b1,1'b1,2'b10,3'd2}},
    // level 2 block after one table
    '{VA0, 2'd1, 48'h1000, 6'd48, mk_tbl(0,0,0,0,48'h2000),
      mk_leaf(0,1,0,0,1,2'b01,2'b10,0,3'd7,48'h00A0_0000,2'b01), 64'h0, 64'h0,
      3'd2, 2'd0, 2'd2, 48'h00A0_4567, 6'd21, 0,1,0, 2'b10, {1'b0,1'b0,2'b01,3'd7}},
    // hierarchical restrictions (R6)
    '{VA0, 2'd0, 48'h1000, 6'd48, mk_tbl(0,2'b10,1,0,48'h2000), mk_tbl(1,2'b01,0,1,48'h3000),
      mk_leaf(0,0,0,0,1,2'b00,2'b01,0,3'd0,48'h00A0_0000,2'b01), 64'h0,
      3'd3, 2'd0, 2'd2, 48'h00A0_4567, 6'd21, 1,1,1, 2'b10, 7'd0},
    // invalid at level 2 (R3 R9)
    '{VA0, 2'd1, 48'h1000, 6'd48, mk_tbl(1,2'b11,1,1,48'h2000), 64'h0, 64'h0, 64'h0,
      3'd2, 2'd1, 2'd2, 48'h0, 6'd0, 0,0,0, 2'b00, 7'd0},
    // block encoding at level 0 (R3)
    '{VA0, 2'd0, 48'h1000, 6'd48, mk_leaf(1,1,1,1,1,2'b11,2'b11,1,3'd7,48'h80_0000_0000,2'b01),
      64'h0, 64'h0, 64'h0, 3'd1, 2'd1, 2'd0, 48'h0, 6'd0, 0,0,0, 2'b00, 7'd0},
    // block encoding at level 3 (R3)
    '{VA0, 2'd3, 48'h5000, 6'd48, mk_leaf(0,0,0,0,1,2'b00,2'b00,0,3'd0,48'h6000,2'b01),
      64'h0, 64'h0, 64'h0, 3'd1, 2'd1, 2'd3, 48'h0, 6'd0, 0,0,0, 2'b00, 7'd0},
    // access flag clear (R7)
    '{VA0, 2'd1, 48'h1000, 6'd48, mk_tbl(0,0,0,0,48'h2000),
      mk_leaf(1,1,0,1,0,2'b11,2'b11,1,3'd3,48'h00A0_0000,2'b01), 64'h0, 64'h0,
      3'd2, 2'd2, 2'd2, 48'h0, 6'd0, 0,0,0, 2'b00, 7'd0},
    // beyond 32-bit output range (R8)
    '{VA0, 2'd1, 48'h1000, 6'd32, mk_leaf(0,0,0,0,1,2'b00,2'b00,0,3'd0,48'h1_0000_0000,2'b01),
      64'h0, 64'h0, 64'h0, 3'd1, 2'd3, 2'd1, 48'h0, 6'd0, 0,0,0, 2'b00, 7'd0},
    // top of 32-bit range is legal (R8)
    '{VA0, 2'd1, 48'h1000, 6'd32, mk_leaf(0,0,0,0,1,2'b00,2'b00,0,3'd0,48'hC000_0000,2'b01),
      64'h0, 64'h0, 64'h0, 3'd1, 2'd0, 2'd1, 48'hC060_4567, 6'd30, 0,0,0, 2'b00, 7'd0},
    // range fault wins over access flag (R8)
    '{VA0, 2'd1, 48'h1000, 6'd32, mk_leaf(0,0,0,0,0,2'b00,2'b00,0,3'd0,48'h1_4000_0000,2'b01),
      64'h0, 64'h0, 64'h0, 3'd1, 2'd3, 2'd1, 48'h0, 6'd0, 0,0,0, 2'b00, 7'd0},
    // bit 0 clear with bit 1 set is invalid (R3)
    '{VA0, 2'd2, 48'h7000, 6'd48, 64'h2, 64'h0, 64'h0, 64'h0,
      3'd1, 2'd1, 2'd2, 48'h0, 6'd0, 0,0,0, 2'b00, 7'd0},
    // top index and all-ones page (R2 R4)
    '{VA1, 2'd3, 48'h9000, 6'd48, mk_leaf(0,0,0,0,1,2'b00,2'b00,0,3'd0,48'hFFFF_FFFF_F000,2'b11),
      64'h0, 64'h0, 64'h0, 3'd1, 2'd0, 2'd3, 48'hFFFF_FFFF_FFFF, 6'd12, 0,0,0, 2'b00, 7'd0}
  };

  task automatic chk(string rq, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  function automatic logic [63:0] pick(vec_t v, int k);
    case (k)
      0: return v.d0;
      1: return v.d1;
      2: return v.d2;
      default: return v.d3;
    endcase
  endfunction

  task automatic run_vec(vec_t v, int stall, string tag);
    logic [47:0] tb;
    logic [47:0] exp_addr;
    int lv, lsb, w;
    @(negedge clk);
    chk("R11", {tag, " ready before start"}, req_ready_o, 1);
    req_valid_i = 1; req_va_i = v.va; req_level_i = v.lvl; req_base_i = v.base; pa_bits_i = v.pab;
    @(negedge clk);
    req_valid_i = 0;
    req_va_i = ~v.va;  // changes after acceptance have no effect
    for (int k = 0; k < int'(v.nrd); k++) begin
      w = 0;
      while (!mem_req_valid_o && w < 50) begin @(negedge clk); w++; end
      lv  = int'(v.lvl) + k;
      lsb = 12 + 9 * (3 - lv);
      tb  = (k == 0) ? v.base : (pick(v, k - 1) & 64'h0000_FFFF_FFFF_F000);
      exp_addr = {tb[47:12], 12'h0} | (((v.va >> lsb) & 48'h1FF) << 3);
      chk("R2", {tag, " descriptor address"}, mem_req_addr_o, exp_addr);
      chk("R11", {tag, " busy"}, req_ready_o, 0);
      for (int s = 0; s < stall; s++) begin
        @(negedge clk);
        chk("R10", {tag, " held request"}, {mem_req_valid_o, mem_req_addr_o}, {1'b1, exp_addr});
      end
      mem_req_ready_i = 1;
      @(negedge clk);
      mem_req_ready_i = 0;
      mem_rsp_valid_i = 1; mem_rsp_data_i = pick(v, k);
      @(negedge clk);
      mem_rsp_valid_i = 0; mem_rsp_data_i = '0;
    end
    w = 0;
    while (!done_o && w < 50) begin @(negedge clk); w++; end
    chk("R11", {tag, " done seen"}, done_o, 1);
    chk("R3",  {tag, " fault code"}, fault_o, v.e_fault);
    chk("R3",  {tag, " end level"}, end_level_o, v.e_lvl);
    chk("R4",  {tag, " output address"}, pa_o, v.e_pa);
    chk("R4",  {tag, " page shift"}, page_shift_o, v.e_shift);
    chk("R6",  {tag, " xn pxn ns ap"}, {xn_o, pxn_o, ns_o, ap_o}, {v.e_xn, v.e_pxn, v.e_ns, v.e_ap});
    chk("R5",  {tag, " contig ng sh attr"}, {contig_o, ng_o, sh_o, attr_idx_o}, v.e_misc);
    @(negedge clk);
    chk("R11", {tag, " done pulse"}, done_o, 0);
    chk("R1",  {tag, " idle after walk"}, {req_ready_o, mem_req_valid_o}, 2'b10);
  endtask

  initial begin
    #(5.0 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_ni = 0; req_valid_i = 0; req_va_i = '0; req_level_i = '0; req_base_i = '0;
    pa_bits_i = 6'd48; mem_req_ready_i = 0; mem_rsp_valid_i = 0; mem_rsp_data_i = '0;
    repeat (3) @(negedge clk);
    chk("R1", "reset ready/req/done", {req_ready_o, mem_req_valid_o, done_o}, 3'b100);
    rst_ni = 1;

    for (int i = 0; i < NV; i++) run_vec(VECS[i], i % 3, $sformatf("vec%0d", i));

    // stray response while idle is ignored (R10)
    @(negedge clk);
    mem_rsp_valid_i = 1; mem_rsp_data_i = mk_tbl(1, 2'b11, 1, 1, 48'hF000);
    @(negedge clk);
    mem_rsp_valid_i = 0; mem_rsp_data_i = '0;
    @(negedge clk);
    chk("R10", "stray response ignored", {req_ready_o, mem_req_valid_o, done_o}, 3'b100);
    run_vec(VECS[0], 0, "after_stray");

    // reset in the middle of a walk (R1)
    @(negedge clk);
    req_valid_i = 1; req_va_i = VA0; req_level_i = 2'd0; req_base_i = 48'h1000;
    @(negedge clk);
    req_valid_i = 0;
    chk("R11", "walk started", mem_req_valid_o, 1);
    rst_ni = 0;
    @(negedge clk);
    chk("R1", "mid-walk reset", {req_ready_o, mem_req_valid_o, done_o}, 3'b100);
    rst_ni = 1;
    run_vec(VECS[3], 2, "after_reset");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule